// File: doc/BRIEF.md
# Heartbeat Sanity Watchdog and Power Supervisor

This block supervises a vehicle's computing chain from a small, always-powered controller. Each monitored source, such as the processor or the main logic device, drives a heartbeat line that it must toggle regularly. When a heartbeat goes quiet, the supervisor first pulses the reset line of that source. If the source does not resume toggling within a grace period, the subsystem it owns is powered down for a fixed off time. It is then powered up again under a fresh reset pulse.

Every reset pulse counts as one recovery. Recoveries are tallied inside a rate window that the first recovery opens. If more recoveries than the allowed maximum fall inside one window, the supervisor gives up on local repair. It removes power from every subsystem at once, holds all resets through power-up, and counts one reboot. Software can also request a power cycle of any single subsystem through a request strobe and an index.

All times are counted in ticks of a prescaled time base, so the defaults (a 0.1 ms tick at 100 MHz) give a 10 ms alive window, a 1 ms reset pulse, a 50 ms grace period, a 100 ms off time and a one second rate window. Monitored source i owns subsystem i, and subsystems with higher indices have no heartbeat.

Top module: `power_supervisor`

## Requirements
- R1: After reset, every power enable is 1, every source reset is 0, every source status is 1 and both counters are 0.
- R2: A source whose heartbeat changes level at least once in every WIN_T ticks stays healthy: status 1, reset 0, power 1.
- R3: When a source's heartbeat has not changed for WIN_T ticks, its reset output rises and stays high for exactly RST_T ticks, and its status drops to 0.
- R4: If the heartbeat changes level within GRACE_T ticks after the reset pulse ends, the source returns to status 1 without any power change.
- R5: If no change arrives within GRACE_T ticks after the reset pulse, power enable i (bit i belongs to source i) goes to 0 for OFF_T ticks and then returns to 1 together with a new RST_T reset pulse.
- R6: Every start of a source reset pulse is one recovery; the recovery counter adds the number of pulses starting in a cycle, so two sources failing in the same cycle add 2.
- R7: A recovery while no rate window is open opens one of RATE_T ticks; if the recoveries inside it exceed MAX_EV, all power enables go to 0 and all resets to 1 for OFF_T ticks, then power returns with all resets held for RST_T more ticks, the reboot counter adds 1, and monitoring restarts with fresh windows.
- R8: Exactly MAX_EV recoveries inside one rate window cause no reboot.
- R9: A request strobe with index sel (0 to NSUB-1, bit sel of the power enables) removes power from that subsystem alone for OFF_T ticks, starting the cycle after the strobe.
- R10: A request for a subsystem that software has already switched off is ignored and does not extend its off time.
- R11: While software holds a monitored subsystem off, its heartbeat check is suspended, and no recovery is counted for it.
- R12: Losing one source's heartbeat never removes power from any other subsystem.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_i | input | NSRC | Heartbeat lines, one per monitored source (asynchronous) |
| sw_cycle_req | input | 1 | Software power-cycle strobe, one cycle |
| sw_cycle_sel | input | $clog2(NSUB) | Index of the subsystem to power-cycle |
| sub_rst_o | output | NSRC | Reset to each monitored source, active high |
| pwr_en_o | output | NSUB | Power enable of each subsystem, 1 = on |
| src_ok_o | output | NSRC | 1 while the source is considered sane |
| reboot_busy_o | output | 1 | 1 while a whole-vehicle reboot is in progress |
| recov_cnt_o | output | CNT_W | Recoveries since reset, wrapping |
| reboot_cnt_o | output | CNT_W | Whole-vehicle reboots since reset, wrapping |

## Verification
The case of interest is two heartbeat sources failing in the very same cycle, so that two recoveries arrive at the rate limiter together and must both be counted. The bench stops both heartbeats at the same clock edge, which keeps the two sources in lockstep through the reset, grace and off phases. It then judges the sum at each step: after the second pair the recovery count must equal the limit with no reboot, and the third pair must push the sum past the limit and start the reboot in exactly that cycle. A second overlap, a software request landing on a subsystem that is already switched off, is checked by the moment power returns.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [1:0] {
        MS_MON  = 2'd0,
        MS_RST  = 2'd1,
        MS_WAIT = 2'd2,
        MS_OFF  = 2'd3
    } mon_state_e;

    typedef enum logic [1:0] {
        RB_IDLE = 2'd0,
        RB_OFF  = 2'd1,
        RB_RST  = 2'd2
    } rb_phase_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrsup_tick.sv
module pwrsup_tick #(
    parameter int TICK_DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_d, div_q;

            always_comb begin
                if (div_q == DW'(TICK_DIV - 1)) div_d = '0;
                else                            div_d = div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick_o = (div_q == DW'(TICK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/pwrsup_hb_mon.sv
module pwrsup_hb_mon
    import pwrsup_pkg::*;
#(
    parameter int WIN_T   = 100,
    parameter int RST_T   = 10,
    parameter int GRACE_T = 500,
    parameter int OFF_T   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hb_i,
    input  logic hold_i,
    input  logic force_i,
    output logic ev_o,
    output logic rst_o,
    output logic off_o,
    output logic ok_o
);
    localparam int MAXT = max2(max2(WIN_T, RST_T), max2(GRACE_T, OFF_T));
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        mon_state_e    state;
        logic [CW-1:0] cnt;
        logic          seen;
        logic          s1;
        logic          s2;
        logic          hq;
    } mon_t;

    mon_t q, d;
    logic tgl, alive;

    always_comb begin
        d     = q;
        ev_o  = 1'b0;
        d.s1  = hb_i;
        d.s2  = q.s1;
        d.hq  = q.s2;
        tgl   = q.s2 ^ q.hq;
        alive = tgl | q.seen;
        if (tick_i)   d.seen = 1'b0;
        else if (tgl) d.seen = 1'b1;

        if (force_i) begin
            d.state = MS_MON;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                MS_MON: begin
                    if (hold_i) begin
                        d.cnt = '0;
                    end else if (tick_i) begin
                        if (alive) begin
                            d.cnt = '0;
                        end else if (q.cnt == CW'(WIN_T - 1)) begin
                            d.state = MS_RST;
                            d.cnt   = '0;
                            ev_o    = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                MS_RST: begin
                    if (tick_i) begin
                        if (q.cnt == CW'(RST_T - 1)) begin
                            d.state = MS_WAIT;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                MS_WAIT: begin
                    if (tick_i) begin
                        if (alive) begin
                            d.state = MS_MON;
                            d.cnt   = '0;
                        end else if (q.cnt == CW'(GRACE_T - 1)) begin
                            d.state = MS_OFF;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                MS_OFF: begin
                    if (tick_i) begin
                        if (q.cnt == CW'(OFF_T - 1)) begin
                            d.state = MS_RST;
                            d.cnt   = '0;
                            ev_o    = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    d.state = MS_MON;
                    d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: MS_MON, cnt: '0, seen: 1'b0, s1: 1'b0, s2: 1'b0, hq: 1'b0};
        else        q <= d;
    end

    assign rst_o = (q.state == MS_RST);
    assign off_o = (q.state == MS_OFF);
    assign ok_o  = (q.state == MS_MON);

    // R3: a reset pulse only begins from healthy monitoring or from power-off
    a_r3_rst_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> ($past(q.state) == MS_MON || $past(q.state) == MS_OFF));

    // R5: power is removed only after the grace period has run out
    a_r5_off_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_o) |-> ($past(q.state) == MS_WAIT));

    // R4: a heartbeat seen during the grace period restores the healthy state
    a_r4_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == MS_WAIT && !force_i && tick_i && alive) |=> ok_o);

    // R11: a held subsystem cannot time out
    a_r11_hold_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && q.state == MS_MON && !force_i) |=> (q.state == MS_MON));
endmodule

// File: rtl/pwrsup_rate.sv
module pwrsup_rate
    import pwrsup_pkg::*;
#(
    parameter int NSRC   = 2,
    parameter int MAX_EV = 4,
    parameter int RATE_T = 10000,
    parameter int OFF_T  = 1000,
    parameter int RST_T  = 10,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [NSRC-1:0]  ev_i,
    output logic             force_o,
    output logic             gpwr_off_o,
    output logic [CNT_W-1:0] recov_cnt_o,
    output logic [CNT_W-1:0] reboot_cnt_o
);
    localparam int EW = $clog2(NSRC + 1);
    localparam int SW = $clog2(MAX_EV + NSRC + 1);
    localparam int WW = $clog2(RATE_T + 1);
    localparam int PW = $clog2(max2(OFF_T, RST_T) + 1);

    typedef struct packed {
        rb_phase_e        phase;
        logic [PW-1:0]    pcnt;
        logic             open;
        logic [WW-1:0]    win;
        logic [SW-1:0]    sum;
        logic [CNT_W-1:0] recov;
        logic [CNT_W-1:0] reboot;
    } rate_t;

    rate_t q, d;
    logic [EW-1:0] ev_n;
    logic [SW-1:0] base, total;
    logic          closing;

    always_comb begin
        d       = q;
        ev_n    = EW'($countones(ev_i));
        d.recov = q.recov + CNT_W'(ev_n);
        closing = q.open && tick_i && (q.win == WW'(RATE_T - 1));
        base    = (q.open && !closing) ? q.sum : '0;
        total   = base + SW'(ev_n);

        unique case (q.phase)
            RB_IDLE: begin
                if (ev_n != '0 && total > SW'(MAX_EV)) begin
                    d.phase  = RB_OFF;
                    d.pcnt   = '0;
                    d.reboot = q.reboot + 1'b1;
                    d.open   = 1'b0;
                    d.sum    = '0;
                    d.win    = '0;
                end else if (ev_n != '0 && (!q.open || closing)) begin
                    d.open = 1'b1;
                    d.win  = '0;
                    d.sum  = total;
                end else if (q.open) begin
                    if (closing) begin
                        d.open = 1'b0;
                        d.sum  = '0;
                    end else begin
                        d.sum = total;
                        if (tick_i) d.win = q.win + 1'b1;
                    end
                end
            end
            RB_OFF: begin
                if (tick_i) begin
                    if (q.pcnt == PW'(OFF_T - 1)) begin
                        d.phase = RB_RST;
                        d.pcnt  = '0;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
            end
            RB_RST: begin
                if (tick_i) begin
                    if (q.pcnt == PW'(RST_T - 1)) begin
                        d.phase = RB_IDLE;
                        d.pcnt  = '0;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
            end
            default: begin
                d.phase = RB_IDLE;
                d.pcnt  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: RB_IDLE, pcnt: '0, open: 1'b0, win: '0,
                           sum: '0, recov: '0, reboot: '0};
        else        q <= d;
    end

    assign force_o      = (q.phase != RB_IDLE);
    assign gpwr_off_o   = (q.phase == RB_OFF);
    assign recov_cnt_o  = q.recov;
    assign reboot_cnt_o = q.reboot;

    // R8: the stored window tally never exceeds the allowed maximum
    a_r8_sum_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.sum <= SW'(MAX_EV));

    // R7: a reboot is counted only when the sequencer leaves idle for power-off
    a_r7_reboot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (reboot_cnt_o != $past(reboot_cnt_o)) |-> (q.phase == RB_OFF && $past(q.phase) == RB_IDLE));
endmodule

// File: rtl/power_supervisor.sv
module power_supervisor
    import pwrsup_pkg::*;
#(
    parameter int NSRC     = 2,
    parameter int NSUB     = 4,
    parameter int TICK_DIV = 10000,
    parameter int WIN_T    = 100,
    parameter int RST_T    = 10,
    parameter int GRACE_T  = 500,
    parameter int OFF_T    = 1000,
    parameter int RATE_T   = 10000,
    parameter int MAX_EV   = 4,
    parameter int CNT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         hb_i,
    input  logic                    sw_cycle_req,
    input  logic [$clog2(NSUB)-1:0] sw_cycle_sel,
    output logic [NSRC-1:0]         sub_rst_o,
    output logic [NSUB-1:0]         pwr_en_o,
    output logic [NSRC-1:0]         src_ok_o,
    output logic                    reboot_busy_o,
    output logic [CNT_W-1:0]        recov_cnt_o,
    output logic [CNT_W-1:0]        reboot_cnt_o
);
    localparam int SELW = $clog2(NSUB);
    localparam int OW   = $clog2(OFF_T + 1);

    typedef struct packed {
        logic [NSUB-1:0]         off;
        logic [NSUB-1:0][OW-1:0] cnt;
    } sw_t;

    logic            tick;
    logic            force_all, gpwr_off;
    logic [NSRC-1:0] mon_ev, mon_rst, mon_off, mon_ok;
    logic [NSUB-1:0] mon_off_sub;
    logic            accept;
    sw_t             q, d;

    pwrsup_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_mon
            pwrsup_hb_mon #(
                .WIN_T   (WIN_T),
                .RST_T   (RST_T),
                .GRACE_T (GRACE_T),
                .OFF_T   (OFF_T)
            ) u_mon (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_i  (tick),
                .hb_i    (hb_i[i]),
                .hold_i  (q.off[i]),
                .force_i (force_all),
                .ev_o    (mon_ev[i]),
                .rst_o   (mon_rst[i]),
                .off_o   (mon_off[i]),
                .ok_o    (mon_ok[i])
            );
        end
        for (genvar i = 0; i < NSUB; i++) begin : g_map
            if (i < NSRC) begin : g_owned
                assign mon_off_sub[i] = mon_off[i];
            end else begin : g_free
                assign mon_off_sub[i] = 1'b0;
            end
        end
    endgenerate

    pwrsup_rate #(
        .NSRC   (NSRC),
        .MAX_EV (MAX_EV),
        .RATE_T (RATE_T),
        .OFF_T  (OFF_T),
        .RST_T  (RST_T),
        .CNT_W  (CNT_W)
    ) u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .ev_i         (mon_ev),
        .force_o      (force_all),
        .gpwr_off_o   (gpwr_off),
        .recov_cnt_o  (recov_cnt_o),
        .reboot_cnt_o (reboot_cnt_o)
    );

    // software power-cycle timers, one per subsystem
    always_comb begin
        d      = q;
        accept = sw_cycle_req && !force_all && (32'(sw_cycle_sel) < NSUB)
                 && !q.off[sw_cycle_sel];
        for (int i = 0; i < NSUB; i++) begin
            if (accept && sw_cycle_sel == SELW'(i)) begin
                d.off[i] = 1'b1;
                d.cnt[i] = '0;
            end else if (q.off[i] && tick) begin
                if (q.cnt[i] == OW'(OFF_T - 1)) begin
                    d.off[i] = 1'b0;
                    d.cnt[i] = '0;
                end else begin
                    d.cnt[i] = q.cnt[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pwr_en_o      = ~(mon_off_sub | q.off | {NSUB{gpwr_off}});
    assign sub_rst_o     = mon_rst | {NSRC{force_all}};
    assign src_ok_o      = mon_ok & ~{NSRC{force_all}};
    assign reboot_busy_o = force_all;

    // R7: during the reboot power-off phase every subsystem is dark and every reset held
    a_r7_reboot_dark: assert property (@(posedge clk) disable iff (!rst_n)
        gpwr_off |-> (pwr_en_o == '0 && sub_rst_o == '1));

    // R6: the recovery counter only moves when a source reset pulse begins
    a_r6_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_cnt_o != $past(recov_cnt_o)) |-> ((mon_rst & ~$past(mon_rst)) != '0));

    // R9: an accepted request darkens the chosen subsystem on the next cycle
    a_r9_req_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cycle_req && !force_all && 32'(sw_cycle_sel) < NSUB) |=> !pwr_en_o[$past(sw_cycle_sel)]);

    generate
        for (genvar i = 0; i < NSUB; i++) begin : g_chk
            // R10: a repeated request never restarts a running off timer
            a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
                (q.off[i] && sw_cycle_req && sw_cycle_sel == SELW'(i))
                |=> (!q.off[i] || q.cnt[i] >= $past(q.cnt[i])));
        end
    endgenerate
endmodule

// File: tb/power_supervisor_bench.sv
module power_supervisor_bench;
    localparam int NSRC = 2;
    localparam int NSUB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] hb = '0;
    logic            sw_cycle_req = 1'b0;
    logic [1:0]      sw_cycle_sel = '0;
    logic [NSRC-1:0] sub_rst_o;
    logic [NSUB-1:0] pwr_en_o;
    logic [NSRC-1:0] src_ok_o;
    logic            reboot_busy_o;
    logic [7:0]      recov_cnt_o;
    logic [7:0]      reboot_cnt_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    power_supervisor #(
        .NSRC(NSRC), .NSUB(NSUB), .TICK_DIV(1), .WIN_T(8), .RST_T(4),
        .GRACE_T(12), .OFF_T(16), .RATE_T(400), .MAX_EV(4), .CNT_W(8)
    ) u_power_supervisor (
        .clk(clk), .rst_n(rst_n), .hb_i(hb),
        .sw_cycle_req(sw_cycle_req), .sw_cycle_sel(sw_cycle_sel),
        .sub_rst_o(sub_rst_o), .pwr_en_o(pwr_en_o), .src_ok_o(src_ok_o),
        .reboot_busy_o(reboot_busy_o), .recov_cnt_o(recov_cnt_o),
        .reboot_cnt_o(reboot_cnt_o)
    );

    // fields: cycles[23:16] mask[15:14] pwr[13:10] rst[9:8] ok[7:6] req[5:0]
    localparam logic [23:0] TBL [9] = '{
        {8'd20, 2'b11, 4'b1111, 2'b00, 2'b11, 6'd2},  // R2 both alive
        {8'd5,  2'b10, 4'b1111, 2'b00, 2'b11, 6'd2},  // R2 still inside window
        {8'd8,  2'b10, 4'b1111, 2'b01, 2'b10, 6'd3},  // R3 reset pulse
        {8'd6,  2'b10, 4'b1111, 2'b00, 2'b10, 6'd3},  // R3 pulse ended, grace
        {8'd14, 2'b10, 4'b1110, 2'b00, 2'b10, 6'd12}, // R12 only own power off (R5)
        {8'd12, 2'b10, 4'b1111, 2'b01, 2'b10, 6'd5},  // R5 power back under reset
        {8'd4,  2'b10, 4'b1111, 2'b00, 2'b10, 6'd4},  // R4 grace again
        {8'd6,  2'b11, 4'b1111, 2'b00, 2'b11, 6'd4},  // R4 recovered
        {8'd30, 2'b11, 4'b1111, 2'b00, 2'b11, 6'd2}   // R2 stays healthy
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] mask);
        @(negedge clk);
        sw_cycle_req = 1'b0;
        hb = hb ^ mask;
    endtask

    task automatic step_req(input logic [1:0] mask, input logic [1:0] sel);
        @(negedge clk);
        sw_cycle_req = 1'b1;
        sw_cycle_sel = sel;
        hb = hb ^ mask;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r0;
        logic [7:0] rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwr", 32'(pwr_en_o), 32'hF);
        chk("R1 rst", 32'(sub_rst_o), 32'h0);
        chk("R1 ok", 32'(src_ok_o), 32'h3);
        chk("R1 counts", {16'h0, recov_cnt_o, reboot_cnt_o}, 32'h0);

        foreach (TBL[k]) begin
            for (int c = 0; c < int'(TBL[k][23:16]); c++) step(TBL[k][15:14]);
            chk($sformatf("R%0d pwr row%0d", TBL[k][5:0], k), 32'(pwr_en_o), 32'(TBL[k][13:10]));
            chk($sformatf("R%0d rst row%0d", TBL[k][5:0], k), 32'(sub_rst_o), 32'(TBL[k][9:8]));
            chk($sformatf("R%0d ok row%0d", TBL[k][5:0], k), 32'(src_ok_o), 32'(TBL[k][7:6]));
        end
        chk("R6 two pulses counted", 32'(recov_cnt_o), 32'd2);

        // let the rate window close
        for (int c = 0; c < 450; c++) step(2'b11);

        // R6/R7/R8: both sources fail in the same cycle
        r0 = 0;
        for (int c = 0; c < 40 && sub_rst_o != 2'b11; c++) step(2'b00);
        chk("R6 simultaneous reset", 32'(sub_rst_o), 32'h3);
        chk("R6 simultaneous count", 32'(recov_cnt_o), 32'd4);
        for (int c = 0; c < 33; c++) step(2'b00);
        chk("R8 limit reached no reboot", 32'(reboot_cnt_o), 32'd0);
        chk("R8 second pulses", 32'(sub_rst_o), 32'h3);
        chk("R8 count at limit", 32'(recov_cnt_o), 32'd6);
        for (int c = 0; c < 31; c++) step(2'b00);
        chk("R7 reboot counted", 32'(reboot_cnt_o), 32'd1);
        chk("R7 all dark", 32'(pwr_en_o), 32'h0);
        chk("R6 third pair counted", 32'(recov_cnt_o), 32'd8);
        for (int c = 0; c < 8; c++) step(2'b11);
        chk("R7 resets held", {28'h0, pwr_en_o[1:0], sub_rst_o}, 32'h3);
        chk("R7 busy", 32'(reboot_busy_o), 32'h1);
        for (int c = 0; c < 10; c++) step(2'b11);
        chk("R7 power back, resets held", {28'h0, pwr_en_o}, 32'hF);
        chk("R7 resets during power-up", 32'(sub_rst_o), 32'h3);
        for (int c = 0; c < 12; c++) step(2'b11);
        chk("R7 monitoring restarted", {28'h0, src_ok_o, sub_rst_o}, 32'hC);

        // R9/R10: software cycle of unmonitored subsystem 3
        step_req(2'b11, 2'd3);
        step(2'b11);
        chk("R9 sub3 off", 32'(pwr_en_o), 32'h7);
        for (int c = 0; c < 6; c++) step(2'b11);
        step_req(2'b11, 2'd3);
        for (int c = 0; c < 8; c++) step(2'b11);
        chk("R10 still off at end", 32'(pwr_en_o), 32'h7);
        step(2'b11);
        chk("R10 not extended", 32'(pwr_en_o), 32'hF);

        // R11: software cycle of monitored subsystem 0 while its heartbeat is silent
        rc = recov_cnt_o;
        step_req(2'b10, 2'd0);
        step(2'b10);
        chk("R11 sub0 off", 32'(pwr_en_o), 32'hE);
        chk("R11 no alarm while held", 32'(src_ok_o), 32'h3);
        for (int c = 0; c < 15; c++) step(2'b10);
        for (int c = 0; c < 24; c++) step(2'b11);
        chk("R11 healthy after", {28'h0, src_ok_o, sub_rst_o}, 32'hC);
        chk("R11 power restored", 32'(pwr_en_o), 32'hF);
        chk("R11 no recovery counted", 32'(recov_cnt_o), 32'(rc));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule